// File: doc/BRIEF.md
# Frequency Watchdog with Safe-Code Fallback

This block guards the frequency-select code that a clock generator runs from. Once software arms it, it counts a programmable number of slow time units. Each unit is nominally 290 ms, and a prescaler elsewhere marks each one with a single-cycle pulse. If software does not service the watchdog before the count runs out, the block sets a sticky alarm. It then replaces the active 5-bit frequency code with a safe code and drives an active-low system reset pulse.

The safe code comes from one of two places, chosen by a source-select input. The first is the strap value latched at power-on. The second is a programmed safe-code field. The block also pulses the reset output whenever the active code changes, and a separate control input can turn that trigger off. The count value loaded at power-on is a parameter, 8 by default, which gives about 2.3 s. The register interface and the PLL sit outside this block.

Top module: `wdog_freq_guard`

## Requirements
- R1: While reset is held, `alarm_o` is 0, `sys_rst_n_o` is 1 and `freq_code_o` is 0. Once reset has been released and a few cycles have passed, `freq_code_o` equals `run_code_i`.
- R2: The counter reloads from `timeout_i` whenever the block is disabled, serviced or cleared. With `wd_en_i` high, the N-th `tick_i` pulse after that reload causes an expiry, and `alarm_o` reads 1 from the next cycle. A count of 0 behaves like a count of 1.
- R3: While `wd_en_i` is 0, ticks do not count down and no expiry occurs.
- R4: `kick_i` reloads the counter. When `kick_i` and `tick_i` arrive in the same cycle, the reload wins and that tick is not counted.
- R5: `alarm_o` stays at 1 until `alarm_clr_i` is pulsed. A clear takes priority over an expiry in the same cycle, and it also reloads the counter.
- R6: On expiry the block captures the safe code and holds it as `freq_code_o` for as long as the alarm lasts. The safe code is `strap_code_i` when `safe_src_i` is 0 and `safe_field_i` when `safe_src_i` is 1. Changes to either safe-code source after expiry have no effect on the held code.
- R7: While no alarm is present, `freq_code_o` equals the `run_code_i` value from one cycle earlier.
- R8: An expiry drives `sys_rst_n_o` low for exactly RST_CYC cycles, starting in the cycle after the expiring tick.
- R9: When `chg_rst_en_i` is 1, any change of `freq_code_o` starts a reset pulse in the same cycle that the new code appears. When `chg_rst_en_i` is 0, a code change produces no pulse.
- R10: While the alarm is set, further ticks are ignored: no countdown, no new expiry and no new reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per time unit |
| wd_en_i | input | 1 | Watchdog armed when 1 |
| timeout_i | input | 8 | Count of time units before expiry |
| kick_i | input | 1 | Service strobe, reloads the counter |
| alarm_clr_i | input | 1 | Clears the sticky alarm |
| safe_src_i | input | 1 | 0: safe code from straps, 1: from field |
| strap_code_i | input | 5 | Power-on latched frequency code |
| safe_field_i | input | 5 | Programmed safe frequency code |
| run_code_i | input | 5 | Normally selected frequency code |
| chg_rst_en_i | input | 1 | Enables reset pulse on code change |
| freq_code_o | output | 5 | Active frequency-select code |
| alarm_o | output | 1 | Sticky watchdog alarm |
| sys_rst_n_o | output | 1 | Active-low system reset pulse |

## Verification
The properties assume that every control input is sampled on the reference clock and is steady at each edge. They also assume that reset is released through the internal synchronizer, so the first cycle after release has a defined previous code. The bench changes its inputs only at falling edges and keeps tick, service and clear as single-cycle events at random rates. It keeps the timeout small so that expiries, clears and code changes overlap often. Directed cases then cover the tie between a tick and a service strobe, a zero count, and a safe-code source changing after the code has been captured.

// File: rtl/wdfg_pkg.sv
package wdfg_pkg;
  localparam int FCODE_W = 5;
  typedef logic [FCODE_W-1:0] fcode_t;
endpackage

// File: rtl/wdfg_timer.sv
module wdfg_timer #(
  parameter int CNT_W     = 8,
  parameter int DEF_COUNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic             clr_i,
  input  logic             alarm_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // reload on clear, disable or service; count only while armed and quiet
  always_comb begin
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    expire_o = 1'b0;
    if (clr_i || !en_i || kick_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_i;
    end else if (tick_i && !alarm_i) begin
      cnt_en = 1'b1;
      if (cnt_q <= ONE) begin
        expire_o = 1'b1;
        cnt_d    = load_i;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(DEF_COUNT);
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdfg_select.sv
module wdfg_select
  import wdfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   expire_i,
  input  logic   clr_i,
  input  logic   safe_src_i,
  input  fcode_t strap_i,
  input  fcode_t field_i,
  input  fcode_t run_i,
  output logic   alarm_o,
  output fcode_t code_o,
  output logic   chg_o
);
  logic   alarm_q, alarm_d;
  fcode_t safe_q, safe_d;
  fcode_t code_q, code_d;
  logic   vld_q;

  always_comb begin
    alarm_d = alarm_q;
    if (clr_i)         alarm_d = 1'b0;
    else if (expire_i) alarm_d = 1'b1;
    safe_d = expire_i ? (safe_src_i ? field_i : strap_i) : safe_q;
    code_d = alarm_d ? safe_d : run_i;
    chg_o  = vld_q && (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      safe_q  <= '0;
      code_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      if (expire_i) safe_q <= safe_d;
      code_q  <= code_d;
      vld_q   <= 1'b1;
    end
  end

  assign alarm_o = alarm_q;
  assign code_o  = code_q;
endmodule

// File: rtl/wdfg_pulse.sv
module wdfg_pulse #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rst_n_o
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [RW-1:0] LEN = RW'(RST_CYC);

  logic [RW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_en = trig_i || (left_q != '0);
    left_d  = trig_i ? LEN : left_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign rst_n_o = (left_q == '0);
endmodule

// File: rtl/wdog_freq_guard.sv
module wdog_freq_guard
  import wdfg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEF_COUNT = 8,
  parameter int RST_CYC   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               wd_en_i,
  input  logic [CNT_W-1:0]   timeout_i,
  input  logic               kick_i,
  input  logic               alarm_clr_i,
  input  logic               safe_src_i,
  input  logic [FCODE_W-1:0] strap_code_i,
  input  logic [FCODE_W-1:0] safe_field_i,
  input  logic [FCODE_W-1:0] run_code_i,
  input  logic               chg_rst_en_i,
  output logic [FCODE_W-1:0] freq_code_o,
  output logic               alarm_o,
  output logic               sys_rst_n_o
);
  logic [1:0] rs_q;
  logic       rst_n_s;
  logic       expire, chg, alarm;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  wdfg_timer #(.CNT_W(CNT_W), .DEF_COUNT(DEF_COUNT)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .tick_i(tick_i), .en_i(wd_en_i),
    .kick_i(kick_i), .clr_i(alarm_clr_i), .alarm_i(alarm),
    .load_i(timeout_i), .expire_o(expire)
  );

  wdfg_select u_sel (
    .clk(clk), .rst_n(rst_n_s), .expire_i(expire), .clr_i(alarm_clr_i),
    .safe_src_i(safe_src_i), .strap_i(strap_code_i), .field_i(safe_field_i),
    .run_i(run_code_i), .alarm_o(alarm), .code_o(freq_code_o), .chg_o(chg)
  );

  wdfg_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n_s), .trig_i(expire | (chg & chg_rst_en_i)),
    .rst_n_o(sys_rst_n_o)
  );

  assign alarm_o = alarm;
endmodule

// File: rtl/wdfg_checker.sv
module wdfg_checker
  import wdfg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   wd_en_i,
  input logic   kick_i,
  input logic   alarm_clr_i,
  input logic   safe_src_i,
  input fcode_t strap_code_i,
  input fcode_t safe_field_i,
  input fcode_t run_code_i,
  input fcode_t freq_code_o,
  input logic   alarm_o,
  input logic   sys_rst_n_o
);
  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  AST_EXPIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en_i |=> !$rose(alarm_o)); // R3
  AST_KICK_BLOCKS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !$rose(alarm_o)); // R4
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o && !alarm_clr_i |=> alarm_o); // R5
  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr_i |=> !alarm_o); // R5
  AST_SAFE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> freq_code_o == ($past(safe_src_i) ? $past(safe_field_i)
                                                        : $past(strap_code_i))); // R6
  AST_SAFE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o && $past(alarm_o) |-> $stable(freq_code_o)); // R6
  AST_RUN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && !alarm_o |-> freq_code_o == $past(run_code_i)); // R7
  AST_RESET_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> !sys_rst_n_o); // R8
endmodule

bind wdog_freq_guard wdfg_checker u_chk (
  .clk(clk), .rst_n(rst_n_s), .wd_en_i(wd_en_i), .kick_i(kick_i),
  .alarm_clr_i(alarm_clr_i), .safe_src_i(safe_src_i),
  .strap_code_i(strap_code_i), .safe_field_i(safe_field_i),
  .run_code_i(run_code_i), .freq_code_o(freq_code_o),
  .alarm_o(alarm_o), .sys_rst_n_o(sys_rst_n_o)
);

// File: tb/wdog_freq_guard_tb.sv
`timescale 1ns/1ps
module wdog_freq_guard_tb;
  localparam int RST_CYC = 16;

  logic clk = 1'b0;
  logic rst_n, tick, en, kick, clr, src, chg_en;
  logic [7:0] to;
  logic [4:0] strap, field, run;
  logic [4:0] freq;
  logic alarm, srst_n;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_cnt, m_alarm, m_safe, m_code, m_rst;

  always #5 clk = ~clk;

  wdog_freq_guard #(.RST_CYC(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wd_en_i(en), .timeout_i(to),
    .kick_i(kick), .alarm_clr_i(clr), .safe_src_i(src), .strap_code_i(strap),
    .safe_field_i(field), .run_code_i(run), .chg_rst_en_i(chg_en),
    .freq_code_o(freq), .alarm_o(alarm), .sys_rst_n_o(srst_n)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  task automatic model();
    int nc, na, ns, ncode;
    bit ex;
    ex = 0; nc = m_cnt;
    if (clr || !en || kick) nc = to;
    else if (tick && m_alarm == 0) begin
      if (m_cnt <= 1) begin ex = 1; nc = to; end
      else nc = m_cnt - 1;
    end
    na = clr ? 0 : (ex ? 1 : m_alarm);
    ns = ex ? (src ? field : strap) : m_safe;
    ncode = (na != 0) ? ns : run;
    if (ex || (chg_en && ncode != m_code)) m_rst = RST_CYC;
    else if (m_rst > 0) m_rst--;
    m_cnt = nc; m_alarm = na; m_safe = ns; m_code = ncode;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(alarm, m_alarm, "R5 model alarm");
    chk(freq, m_code, "R7 model code");
    chk(srst_n, (m_rst == 0) ? 1 : 0, "R8 model reset");
  endtask

  task automatic drain();
    repeat (RST_CYC + 1) step();
  endtask

  function automatic string tagn(input string t);
    return t;
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog run hung actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'h5EED_0219));
    rst_n = 0; tick = 0; en = 0; kick = 0; clr = 0; src = 0; chg_en = 1;
    to = 8'd3; strap = 5'h0A; field = 5'h13; run = 5'h04;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(alarm, 0, "R1 alarm in reset");
    chk(srst_n, 1, "R1 reset out in reset");
    chk(freq, 0, "R1 code in reset");
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(freq, 5'h04, "R1 code after reset");
    m_cnt = 3; m_alarm = 0; m_safe = 0; m_code = 5'h04; m_rst = 0;

    // R3: disabled, ticks ignored
    tick = 1; repeat (6) step(); tick = 0;
    chk(alarm, 0, "R3 no expiry while disabled");

    // R2: N=3 expiry on third tick; R6 strap source; R8 pulse width
    en = 1; step();
    tick = 1; step(); step();
    chk(alarm, 0, "R2 not yet expired");
    step();
    chk(alarm, 1, "R2 expired on third tick");
    chk(freq, 5'h0A, "R6 strap safe code");
    tick = 0;
    lows = (srst_n == 0) ? 1 : 0;
    repeat (RST_CYC + 3) begin step(); if (!srst_n) lows++; end
    chk(lows, RST_CYC, "R8 pulse length");

    // R10: frozen while alarm
    tick = 1; repeat (10) step(); tick = 0;
    chk(alarm, 1, "R10 alarm held");
    chk(srst_n, 1, "R10 no new pulse");

    // R5: clear
    clr = 1; step(); clr = 0;
    chk(alarm, 0, "R5 alarm cleared");
    chk(freq, 5'h04, "R5 code back to run");
    drain();

    // R4: kick wins over tick
    tick = 1; step(); step();
    kick = 1; step(); kick = 0;
    step(); step();
    chk(alarm, 0, "R4 kick reloaded");
    step();
    chk(alarm, 1, "R4 expiry after reload");
    tick = 0; clr = 1; step(); clr = 0; drain();

    // R6: field source, N=0, snapshot
    src = 1; to = 8'd0; kick = 1; step(); kick = 0;
    tick = 1; step(); tick = 0;
    chk(alarm, 1, "R2 zero count expires on first tick");
    chk(freq, 5'h13, "R6 field safe code");
    field = 5'h1F; strap = 5'h01; step();
    chk(freq, 5'h13, "R6 snapshot held");
    clr = 1; step(); clr = 0; drain();

    // R9: change-triggered reset
    en = 0; chg_en = 0; run = 5'h07; step();
    chk(freq, 5'h07, "R7 code follows run");
    chk(srst_n, 1, "R9 no pulse when disabled");
    chg_en = 1; run = 5'h09; step();
    chk(srst_n, 0, "R9 pulse on change");
    drain();

    // constrained random mix
    to = 8'd2;
    for (int i = 0; i < 3000; i++) begin
      en   = ($urandom % 10) != 0;
      tick = ($urandom % 3) == 0;
      kick = ($urandom % 16) == 0;
      clr  = ($urandom % 40) == 0;
      if ($urandom % 20 == 0) run = 5'($urandom);
      if ($urandom % 50 == 0) begin strap = 5'($urandom); field = 5'($urandom); end
      if ($urandom % 25 == 0) src = ~src;
      if ($urandom % 100 == 0) chg_en = ~chg_en;
      if ($urandom % 30 == 0) to = 8'($urandom % 5);
      step();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule